// File: doc/BRIEF.md
# Serial Byte Transmitter with Transfer-Engine Pacing

This block drives a single asynchronous serial output. Bytes arrive through a one-cycle write strobe and wait in holding storage. In plain mode that storage holds a single byte. In queued mode it holds `DEPTH` bytes. Each byte moves into a shift register and leaves the line as ten bit periods, each period set by an external baud tick: one low start bit, eight data bits least significant first, and one high stop bit. A transfer engine is meant to feed the block with no software involvement. It watches `dma_req` and writes one byte each time the request is high. The completion flag lets software find out when the whole burst has physically left the line, which is safe to do before the transmitter is turned off.

A state machine sequences the line. Its states are OFF, PREAMBLE, IDLE, START, DATA and STOP, and its transitions are:
- any state to OFF when `enable` is low;
- OFF to PREAMBLE once enabled;
- PREAMBLE to IDLE on the tenth tick;
- IDLE to START on a tick with a byte waiting, which loads the byte;
- START to DATA on a tick;
- DATA to STOP on the tick that ends bit 7;
- STOP to START on a tick with another byte waiting (back-to-back);
- STOP to IDLE on a tick with nothing waiting, which sets the completion flag.

Top module: `uart_dma_tx`

## Requirements
- R1: After reset, `tx`=1, `txe`=1, `dma_req`=0, `tc`=0 and `ovr`=0.
- R2: While `enable` is low, `tx` is held at 1, `txe` is forced to 1 and `dma_req` is 0. Data writes are ignored and do not set `ovr`. Any queued bytes are discarded.
- R3: One cycle after `enable` is seen high, the line stays high for ten baud ticks (the preamble) before any start bit. Bytes written during the preamble are kept.
- R4: A frame is a start bit of 0, then `wr_data` bits 0 through 7, then a stop bit of 1. The line changes only in the cycle after a cycle with `baud_tick`=1, and each bit lasts exactly one tick interval.
- R5: `txe` is 1 exactly when the holding storage is empty. It drops the cycle after an accepted write. It returns to 1 the cycle after the last stored byte is loaded into the shifter.
- R6: With `fifo_mode`=0, storage holds one byte and `dma_req` = `enable` AND `txe`.
- R7: With `fifo_mode`=1, storage holds `DEPTH` bytes and `dma_req` is 1 while enabled with fewer than `DEPTH` bytes stored.
- R8: When a byte is waiting at the tick that ends a stop bit, the next start bit begins at once, with no idle bit between frames.
- R9: `tc` rises the cycle after the tick that ends a stop bit with no byte waiting. It stays 0 between frames of a back-to-back burst.
- R10: Writing `clr_wr`=1 with `clr_bits[0]`=1 clears `tc` on the next cycle. A set in the same cycle wins over the clear.
- R11: A write while enabled and storage is full (one byte in plain mode, `DEPTH` in queued mode, counted before any same-cycle load) is discarded and sets sticky `ovr`. `clr_wr`=1 with `clr_bits[1]`=1 clears it. A set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Transmitter enable |
| fifo_mode | input | 1 | 1 selects the DEPTH-entry queue, 0 a single data register |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | 8 | Byte to transmit |
| clr_wr | input | 1 | Clear-register write strobe |
| clr_bits | input | 2 | Write-one-to-clear: bit 0 clears tc, bit 1 clears ovr |
| tx | output | 1 | Serial line, idle high |
| dma_req | output | 1 | Request for one more byte |
| txe | output | 1 | Holding storage empty |
| tc | output | 1 | Transmission complete |
| ovr | output | 1 | Sticky write-overflow status |

## Verification
The bench builds the block with `DEPTH`=4 and ten preamble bits. It drives a baud tick every third cycle, so full frames, preambles and multi-frame bursts fit into a short run. The depth of four lets a nine-byte burst in queued mode keep the queue filling and draining while frames go out back-to-back. A six-write burst fills that queue and then overruns it. A single-entry run in plain mode shows the overflow on the second write. Holding the clear strobe active across the end of a burst exercises the case where set and clear land in the same cycle. Dropping the enable in the middle of a frame exercises the flush and a fresh preamble.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    localparam int DATA_BITS = 8;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_PREAMBLE,
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } tx_state_t;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DEPTH = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                flush,
    input  logic                                fifo_mode,
    input  logic                                push_req,
    input  logic [uart_tx_pkg::DATA_BITS-1:0]   push_data,
    input  logic                                pop,
    output logic [uart_tx_pkg::DATA_BITS-1:0]   head,
    output logic                                empty,
    output logic                                full,
    output logic                                overflow_evt
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [uart_tx_pkg::DATA_BITS-1:0] mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt, cap;
    logic          accept, do_pop;

    assign cap          = fifo_mode ? CW'(DEPTH) : CW'(1);
    assign empty        = (cnt == '0);
    assign full         = (cnt >= cap);
    assign accept       = push_req && !full;
    assign overflow_evt = push_req && full;
    assign do_pop       = pop && !empty;
    assign head         = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (accept) wr_ptr <= bump(wr_ptr);
            if (do_pop) rd_ptr <= bump(rd_ptr);
            cnt <= cnt + CW'(accept) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (accept && !flush) mem[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm #(
    parameter int PRE_BITS = 10
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                enable,
    input  logic                                baud_tick,
    input  logic                                data_avail,
    input  logic [uart_tx_pkg::DATA_BITS-1:0]   head_data,
    output logic                                pop,
    output logic                                done_evt,
    output logic                                tx
);
    import uart_tx_pkg::*;

    localparam int MAXC = (PRE_BITS > DATA_BITS) ? PRE_BITS : DATA_BITS;
    localparam int CNTW = $clog2(MAXC);
    localparam int IDXW = $clog2(DATA_BITS);

    tx_state_t             state, nxt;
    logic [CNTW-1:0]       cnt;
    logic [DATA_BITS-1:0]  shreg;

    // transition logic
    always_comb begin
        nxt      = state;
        pop      = 1'b0;
        done_evt = 1'b0;
        if (!enable) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:      nxt = ST_PREAMBLE;
                ST_PREAMBLE: if (baud_tick && cnt == CNTW'(PRE_BITS - 1)) nxt = ST_IDLE;
                ST_IDLE:     if (baud_tick && data_avail) begin
                                 nxt = ST_START;
                                 pop = 1'b1;
                             end
                ST_START:    if (baud_tick) nxt = ST_DATA;
                ST_DATA:     if (baud_tick && cnt == CNTW'(DATA_BITS - 1)) nxt = ST_STOP;
                ST_STOP:     if (baud_tick) begin
                                 if (data_avail) begin
                                     nxt = ST_START;
                                     pop = 1'b1;
                                 end else begin
                                     nxt      = ST_IDLE;
                                     done_evt = 1'b1;
                                 end
                             end
                default:     nxt = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt   <= '0;
            shreg <= '0;
        end else begin
            state <= nxt;
            if (nxt != state)   cnt <= '0;
            else if (baud_tick) cnt <= cnt + CNTW'(1);
            if (pop) shreg <= head_data;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_START: tx = 1'b0;
            ST_DATA:  tx = shreg[cnt[IDXW-1:0]];
            default:  tx = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_tx_flags.sv
module uart_tx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic tc_set,
    input  logic tc_clr,
    input  logic ovr_set,
    input  logic ovr_clr,
    output logic tc,
    output logic ovr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc  <= 1'b0;
            ovr <= 1'b0;
        end else begin
            if (tc_set)       tc <= 1'b1;
            else if (tc_clr)  tc <= 1'b0;
            if (ovr_set)      ovr <= 1'b1;
            else if (ovr_clr) ovr <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_dma_tx.sv
module uart_dma_tx #(
    parameter int DEPTH    = 4,
    parameter int PRE_BITS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       fifo_mode,
    input  logic       baud_tick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       clr_wr,
    input  logic [1:0] clr_bits,
    output logic       tx,
    output logic       dma_req,
    output logic       txe,
    output logic       tc,
    output logic       ovr
);
    logic [7:0] head;
    logic       empty, full, ovf_evt, pop, done_evt;

    uart_tx_hold #(.DEPTH(DEPTH)) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (!enable),
        .fifo_mode    (fifo_mode),
        .push_req     (wr_en && enable),
        .push_data    (wr_data),
        .pop          (pop),
        .head         (head),
        .empty        (empty),
        .full         (full),
        .overflow_evt (ovf_evt)
    );

    uart_tx_fsm #(.PRE_BITS(PRE_BITS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .baud_tick  (baud_tick),
        .data_avail (!empty),
        .head_data  (head),
        .pop        (pop),
        .done_evt   (done_evt),
        .tx         (tx)
    );

    uart_tx_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .tc_set  (done_evt),
        .tc_clr  (clr_wr && clr_bits[0]),
        .ovr_set (ovf_evt),
        .ovr_clr (clr_wr && clr_bits[1]),
        .tc      (tc),
        .ovr     (ovr)
    );

    assign txe     = !enable || empty;
    assign dma_req = enable && (fifo_mode ? !full : empty);
endmodule

// File: rtl/uart_dma_tx_chk.sv
module uart_dma_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       fifo_mode,
    input logic       wr_en,
    input logic       clr_wr,
    input logic [1:0] clr_bits,
    input logic       tx,
    input logic       txe,
    input logic       dma_req,
    input logic       tc,
    input logic       ovr
);
    // R2
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && $past(!enable)) |-> (tx && txe && !dma_req));

    // R5
    txe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && wr_en && txe) ##1 enable |-> !txe);

    // R6
    plain_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !fifo_mode) |-> (dma_req == txe));

    // R9
    tc_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tc) |-> tx);

    // R10
    tc_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tc) |-> $past(clr_wr && clr_bits[0]));

    // R11
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !(clr_wr && clr_bits[1])) |=> ovr);
endmodule

bind uart_dma_tx uart_dma_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .fifo_mode (fifo_mode),
    .wr_en     (wr_en),
    .clr_wr    (clr_wr),
    .clr_bits  (clr_bits),
    .tx        (tx),
    .txe       (txe),
    .dma_req   (dma_req),
    .tc        (tc),
    .ovr       (ovr)
);

// File: tb/sim_uart_dma_tx.sv
`timescale 1ns/1ps
module sim_uart_dma_tx;
    localparam int DEPTH = 4;
    localparam int PRE   = 10;

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, fifo_mode = 1'b0, baud_tick = 1'b0;
    logic wr_en = 1'b0, clr_wr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] clr_bits = '0;
    logic tx, dma_req, txe, tc, ovr;

    int checks = 0, errors = 0, cycles = 0, tdiv = 0;

    uart_dma_tx #(.DEPTH(DEPTH), .PRE_BITS(PRE)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fifo_mode(fifo_mode),
        .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
        .clr_wr(clr_wr), .clr_bits(clr_bits), .tx(tx), .dma_req(dma_req),
        .txe(txe), .tc(tc), .ovr(ovr)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        tdiv      = (tdiv + 1) % 3;
        baud_tick = (tdiv == 0);
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // behavioural reference: 0 off, 1 preamble, 2 idle, 3 start, 4 data, 5 stop
    int         ph = 0, mcnt = 0;
    logic [7:0] q[$];
    logic [7:0] sh = '0;
    bit         mtc = 0, movr = 0, b2b = 0, tclr_now = 0;

    always @(posedge clk) begin
        int  cap;
        bit  popped, tcset, fullnow;
        if (!rst_n) begin
            ph = 0; mcnt = 0; q.delete(); mtc = 0; movr = 0; b2b = 0; tclr_now = 0;
        end else begin
            cap = fifo_mode ? DEPTH : 1;
            popped = 0; tcset = 0; b2b = 0;
            fullnow = (q.size() >= cap);
            if (!enable) begin
                ph = 0; q.delete();
            end else begin
                case (ph)
                    0: begin ph = 1; mcnt = 0; end
                    1: if (baud_tick) begin
                           mcnt++;
                           if (mcnt == PRE) begin ph = 2; mcnt = 0; end
                       end
                    2: if (baud_tick && q.size() > 0) begin ph = 3; popped = 1; end
                    3: if (baud_tick) begin ph = 4; mcnt = 0; end
                    4: if (baud_tick) begin
                           if (mcnt == 7) ph = 5; else mcnt++;
                       end
                    5: if (baud_tick) begin
                           if (q.size() > 0) begin ph = 3; popped = 1; b2b = 1; end
                           else begin ph = 2; tcset = 1; end
                       end
                    default: ph = 0;
                endcase
                if (popped) sh = q.pop_front();
                if (wr_en) begin
                    if (fullnow) movr = 1;
                    else q.push_back(wr_data);
                end
            end
            tclr_now = clr_wr && clr_bits[0];
            if (clr_wr && clr_bits[0]) mtc = 0;
            if (clr_wr && clr_bits[1] && !(enable && wr_en && fullnow)) movr = 0;
            if (tcset) mtc = 1;
        end
    end

    always @(posedge clk) begin
        logic etx;
        int   cap;
        cycles++;
        #1;
        if (rst_n) begin
            cap = fifo_mode ? DEPTH : 1;
            etx = (ph == 3) ? 1'b0 : (ph == 4) ? sh[mcnt] : 1'b1;
            if (ph == 1)      chk("R3 preamble tx", tx, etx);
            else if (ph == 0) chk("R2 disabled tx", tx, etx);
            else if (b2b)     chk("R8 back-to-back start", tx, etx);
            else              chk("R4 frame tx", tx, etx);
            chk("R5 txe", txe, !enable || q.size() == 0);
            if (fifo_mode) chk("R7 queued dma_req", dma_req, enable && q.size() < cap);
            else           chk("R6 plain dma_req", dma_req, enable && q.size() == 0);
            if (tclr_now)  chk("R10 tc clear", tc, mtc);
            else           chk("R9 tc", tc, mtc);
            chk("R11 ovr", ovr, movr);
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    task automatic dma_send(input int n, input logic [7:0] base);
        int sent = 0;
        while (sent < n) begin
            @(negedge clk);
            if (dma_req) begin
                wr_en = 1'b1; wr_data = base + 8'(sent * 37); sent++;
            end else wr_en = 1'b0;
        end
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wait_tc();
        while (!tc) @(negedge clk);
    endtask

    task automatic clear(input logic [1:0] bits);
        @(negedge clk); clr_wr = 1'b1; clr_bits = bits;
        @(negedge clk); clr_wr = 1'b0; clr_bits = '0;
    endtask

    task automatic burst_writes(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); wr_en = 1'b1; wr_data = base ^ 8'(i * 29);
        end
        @(negedge clk); wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 tx", tx, 1'b1);
        chk("R1 txe", txe, 1'b1);
        chk("R1 dma_req", dma_req, 1'b0);
        chk("R1 tc", tc, 1'b0);
        chk("R1 ovr", ovr, 1'b0);
        rst_n = 1'b1;

        // R2 writes while disabled are ignored
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h55;
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk);
        chk("R2 txe after ignored write", txe, 1'b1);
        chk("R2 no overflow", ovr, 1'b0);
        chk("R2 no request", dma_req, 1'b0);

        // plain mode burst of three
        enable = 1'b1;
        dma_send(3, 8'hA5);
        wait_tc();
        clear(2'b01);

        // plain-mode overflow on the second write
        burst_writes(2, 8'h3C);
        wait_tc();
        clear(2'b11);

        // queued mode burst of nine
        fifo_mode = 1'b1;
        dma_send(9, 8'h12);
        wait_tc();
        clear(2'b01);

        // queue overrun
        burst_writes(6, 8'hC3);
        wait_tc();
        clear(2'b11);

        // disable in mid-frame, then restart with a new preamble
        dma_send(2, 8'h81);
        repeat (20) @(negedge clk);
        enable = 1'b0;
        repeat (5) @(negedge clk);
        chk("R2 flushed txe", txe, 1'b1);
        enable = 1'b1;
        dma_send(1, 8'h6E);

        // R10: hold clear active across the end of the burst; set wins
        @(negedge clk); clr_wr = 1'b1; clr_bits = 2'b01;
        wait_tc();
        clr_wr = 1'b0; clr_bits = '0;
        @(negedge clk);
        chk("R10 set wins over clear", tc, 1'b1);
        clear(2'b01);
        @(negedge clk);
        chk("R10 cleared", tc, 1'b0);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule